// File: doc/BRIEF.md
# Serial Transmitter with Port Fallback

This block serialises bytes onto a single transmit line while its enable input is high. Each byte is framed as a low start bit, the data bits least significant first, an optional parity bit and one high stop bit. Every bit lasts one period of an externally supplied bit tick. A one-byte holding register and its empty flag sit in front of the shifter. Software writes a byte when the flag shows empty, and the shifter takes the byte on the next tick.

When the enable input is low, the line stops being a transmitter output and becomes a plain port pin. Its level comes from a port-level input and its output enable from a port-direction input. Software uses this to park the line at mark before enabling, or to force a break. Dropping the enable resets the shifter and the holding register at once, wherever the frame stands. In clocked synchronous operation, any receive error flag that is set holds back the start of a new frame.

Top module: `uart_tx_portmux`

## Requirements
- R1: While reset is high, and on the first cycle after it, tx_out is 1, tx_oe is 0 and tde is 1.
- R2: A write (wr_valid high) is accepted only when tde is 1 and tx_en is 1. tde then reads 0 on the next cycle. Writes made while tde is 0, or while tx_en is 0, change neither tde nor the byte that is later sent.
- R3: With tx_en high, a frame is a 0 start bit, then the 8 data bits LSB first, then a 1 stop bit. Each bit lasts exactly one tick interval, and the line rests at 1 between frames.
- R4: When parity_en is 1, a parity bit follows the last data bit. With parity_odd 0 it is the XOR of the data bits (even parity); with parity_odd 1 it is that value inverted.
- R5: A frame starts on the first bit tick at which tde is 0 and the interlock allows it. On that same tick the byte moves into the shifter and tde returns to 1. tx_out shows the start bit one cycle after that tick edge.
- R6: While tx_en is 0, tx_out follows port_dr and tx_oe follows port_ddr, each one cycle after the inputs. With port_ddr 0 the pin is released (tx_oe 0).
- R7: tx_en going low in any frame position returns the shifter to idle and sets tde to 1, discarding the byte in flight and any byte waiting. After tx_en is raised again the line is at 1, and the next written byte is sent as a complete frame.
- R8: When sync_mode is 1 and any of err_overrun, err_framing or err_parity is 1, no frame starts and tde stays 0. The frame starts on the first tick after the flags clear. When sync_mode is 0 the flags have no effect.
- R9: While tx_en is 1, tx_oe is 1 from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| tx_en | input | 1 | Transmitter enable; 0 selects port fallback and aborts |
| sync_mode | input | 1 | Clocked synchronous operation; arms the error interlock |
| parity_en | input | 1 | Append a parity bit |
| parity_odd | input | 1 | 1 selects odd parity, 0 even |
| port_dr | input | 1 | Port level used while tx_en is 0 |
| port_ddr | input | 1 | Port direction used while tx_en is 0 (1 drives) |
| wr_valid | input | 1 | Write strobe for wr_data |
| wr_data | input | 8 | Byte to transmit |
| err_overrun | input | 1 | Receiver overrun flag |
| err_framing | input | 1 | Receiver framing error flag |
| err_parity | input | 1 | Receiver parity error flag |
| tx_out | output | 1 | Transmit line level |
| tx_oe | output | 1 | Transmit line output enable |
| tde | output | 1 | Holding register empty |

## Verification
The abort and a bit-tick advance can land in the same cycle. The bench lowers tx_en on the very cycle a tick pulse arrives mid-frame, with the port set up for break. The abort must win: the next cycle shows the port level 0, a driven pin and tde at 1. After re-enabling, the line must sit at 1 and carry a clean full frame. A second collision is an error flag present on the tick that would otherwise start a frame. There the bench expects the line to stay at 1 and tde to stay 0 until the flag is removed.

// File: rtl/uart_txpm_pkg.sv
package uart_txpm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;
endpackage

// File: rtl/uart_txpm_holding.sv
module uart_txpm_holding #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic [DATA_W-1:0] hold_q,
  output logic              empty_q
);
  always_ff @(posedge clk) begin
    if (rst || !tx_en) begin
      hold_q  <= '0;
      empty_q <= 1'b1;
    end else if (take) begin
      empty_q <= 1'b1;
    end else if (wr_valid && empty_q) begin
      hold_q  <= wr_data;
      empty_q <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_txpm_shifter.sv
module uart_txpm_shifter
  import uart_txpm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              bit_tick,
  input  logic              ready,
  input  logic              allow,
  input  logic              parity_en,
  input  logic              parity_odd,
  input  logic [DATA_W-1:0] hold_data,
  output logic              take,
  output logic              line
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  tx_state_e         state_q;
  logic [DATA_W-1:0] shreg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              par_q;
  logic              par_on_q;

  assign take = bit_tick && tx_en && (state_q == ST_IDLE) && ready && allow;

  always_ff @(posedge clk) begin
    if (rst || !tx_en) begin
      state_q  <= ST_IDLE;
      shreg_q  <= '0;
      cnt_q    <= '0;
      par_q    <= 1'b0;
      par_on_q <= 1'b0;
    end else if (bit_tick) begin
      case (state_q)
        ST_IDLE: begin
          if (take) begin
            shreg_q  <= hold_data;
            par_q    <= (^hold_data) ^ parity_odd;
            par_on_q <= parity_en;
            state_q  <= ST_START;
          end
        end
        ST_START: begin
          cnt_q   <= '0;
          state_q <= ST_DATA;
        end
        ST_DATA: begin
          shreg_q <= shreg_q >> 1;
          if (cnt_q == LAST_BIT) begin
            state_q <= par_on_q ? ST_PAR : ST_STOP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_PAR:  state_q <= ST_STOP;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state_q)
      ST_START: line = 1'b0;
      ST_DATA:  line = shreg_q[0];
      ST_PAR:   line = par_q;
      default:  line = 1'b1;
    endcase
  end
endmodule

// File: rtl/uart_txpm_pinmux.sv
module uart_txpm_pinmux (
  input  logic clk,
  input  logic rst,
  input  logic tx_en,
  input  logic frame_line,
  input  logic port_dr,
  input  logic port_ddr,
  output logic tx_out,
  output logic tx_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_out <= 1'b1;
      tx_oe  <= 1'b0;
    end else if (tx_en) begin
      tx_out <= frame_line;
      tx_oe  <= 1'b1;
    end else begin
      tx_out <= port_dr;
      tx_oe  <= port_ddr;
    end
  end
endmodule

// File: rtl/uart_tx_portmux.sv
module uart_tx_portmux #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic              tx_en,
  input  logic              sync_mode,
  input  logic              parity_en,
  input  logic              parity_odd,
  input  logic              port_dr,
  input  logic              port_ddr,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              err_overrun,
  input  logic              err_framing,
  input  logic              err_parity,
  output logic              tx_out,
  output logic              tx_oe,
  output logic              tde
);
  logic [DATA_W-1:0] hold_q;
  logic              take;
  logic              frame_line;
  logic              allow;

  assign allow = !(sync_mode && (err_overrun || err_framing || err_parity));

  uart_txpm_holding #(.DATA_W(DATA_W)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .tx_en    (tx_en),
    .wr_valid (wr_valid),
    .wr_data  (wr_data),
    .take     (take),
    .hold_q   (hold_q),
    .empty_q  (tde)
  );

  uart_txpm_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .tx_en      (tx_en),
    .bit_tick   (bit_tick),
    .ready      (!tde),
    .allow      (allow),
    .parity_en  (parity_en),
    .parity_odd (parity_odd),
    .hold_data  (hold_q),
    .take       (take),
    .line       (frame_line)
  );

  uart_txpm_pinmux u_pin (
    .clk        (clk),
    .rst        (rst),
    .tx_en      (tx_en),
    .frame_line (frame_line),
    .port_dr    (port_dr),
    .port_ddr   (port_ddr),
    .tx_out     (tx_out),
    .tx_oe      (tx_oe)
  );
endmodule

// File: rtl/uart_txpm_checker.sv
module uart_txpm_checker (
  input logic clk,
  input logic rst,
  input logic tx_en,
  input logic sync_mode,
  input logic port_dr,
  input logic port_ddr,
  input logic wr_valid,
  input logic err_overrun,
  input logic err_framing,
  input logic err_parity,
  input logic tx_out,
  input logic tx_oe,
  input logic tde
);
  assert_oe_enabled_R9: assert property (@(posedge clk) disable iff (rst)
    tx_en |=> tx_oe);

  assert_port_follow_R6: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> (tx_out == $past(port_dr)) && (tx_oe == $past(port_ddr)));

  assert_write_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && tde && tx_en) |=> !tde);

  assert_abort_empty_R7: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> tde);

  assert_interlock_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (tx_en && $past(tx_en) && !tde && sync_mode &&
     (err_overrun || err_framing || err_parity)) |=> !tde);

  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (tx_out && !tx_oe && tde));
endmodule

bind uart_tx_portmux uart_txpm_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .tx_en       (tx_en),
  .sync_mode   (sync_mode),
  .port_dr     (port_dr),
  .port_ddr    (port_ddr),
  .wr_valid    (wr_valid),
  .err_overrun (err_overrun),
  .err_framing (err_framing),
  .err_parity  (err_parity),
  .tx_out      (tx_out),
  .tx_oe       (tx_oe),
  .tde         (tde)
);

// File: tb/tb_uart_tx_portmux.sv
module tb_uart_tx_portmux;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_tick = 1'b0;
  logic       tx_en = 1'b0;
  logic       sync_mode = 1'b0;
  logic       parity_en = 1'b0;
  logic       parity_odd = 1'b0;
  logic       port_dr = 1'b1;
  logic       port_ddr = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       err_overrun = 1'b0;
  logic       err_framing = 1'b0;
  logic       err_parity = 1'b0;
  logic       tx_out;
  logic       tx_oe;
  logic       tde;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  uart_tx_portmux dut (
    .clk (clk), .rst (rst), .bit_tick (bit_tick), .tx_en (tx_en),
    .sync_mode (sync_mode), .parity_en (parity_en), .parity_odd (parity_odd),
    .port_dr (port_dr), .port_ddr (port_ddr), .wr_valid (wr_valid),
    .wr_data (wr_data), .err_overrun (err_overrun), .err_framing (err_framing),
    .err_parity (err_parity), .tx_out (tx_out), .tx_oe (tx_oe), .tde (tde)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one tick pulse; returns once the line reflects the new bit
  task automatic tick();
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic write_byte(input logic [7:0] d);
    wr_valid = 1'b1;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
    wr_data  = 8'h00;
  endtask

  // expects a pending byte; runs the frame and compares it with the model
  task automatic recv_check(input logic [7:0] d, input bit pe, input bit po);
    logic [7:0] got;
    logic       pbit;
    logic       sbit;
    logic       stop_bit;
    logic       idle_bit;
    logic       exp_par;
    logic       tde_after;
    got = 8'h00;
    pbit = 1'b0;
    tick();
    sbit = tx_out;
    tde_after = tde;
    for (int i = 0; i < 8; i++) begin
      tick();
      got[i] = tx_out;
    end
    if (pe) begin
      tick();
      pbit = tx_out;
    end
    tick();
    stop_bit = tx_out;
    tick();
    idle_bit = tx_out;
    chk(sbit == 1'b0 && tde_after == 1'b1, "R5", {sbit, tde_after}, 2'b01);
    chk(got == d && stop_bit && idle_bit, "R3",
        {got, stop_bit, idle_bit}, {d, 2'b11});
    if (pe) begin
      exp_par = 1'b0;
      for (int i = 0; i < 8; i++) exp_par = exp_par ^ d[i];
      if (po) exp_par = ~exp_par;
      chk(pbit == exp_par, "R4", pbit, exp_par);
    end
  endtask

  task automatic send_check(input logic [7:0] d, input bit pe, input bit po);
    parity_en  = pe;
    parity_odd = po;
    write_byte(d);
    chk(tde == 1'b0, "R2", tde, 1'b0);
    recv_check(d, pe, po);
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tx_en = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(tx_out == 1'b1 && tx_oe == 1'b0 && tde == 1'b1, "R1",
        {tx_out, tx_oe, tde}, 3'b101);
    rst = 1'b0;
    @(negedge clk);
    // R9: enabled drives the pin
    chk(tx_oe == 1'b1 && tx_out == 1'b1, "R9", {tx_oe, tx_out}, 2'b11);

    // R3/R4/R5 sweep: every byte under every parity setting
    for (int m = 0; m < 3; m++) begin
      for (int b = 0; b < 256; b++) begin
        send_check(8'(b), m != 0, m == 2);
      end
    end
    parity_en = 1'b0;
    parity_odd = 1'b0;

    // R6: port fallback, all level/direction combinations
    tx_en = 1'b0;
    for (int c = 0; c < 4; c++) begin
      port_dr  = c[0];
      port_ddr = c[1];
      @(negedge clk);
      chk(tx_out == c[0] && tx_oe == c[1], "R6", {tx_out, tx_oe}, {c[0], c[1]});
    end

    // R2: write while disabled is dropped
    port_dr = 1'b1;
    port_ddr = 1'b1;
    write_byte(8'h77);
    chk(tde == 1'b1, "R2", tde, 1'b1);
    tx_en = 1'b1;
    @(negedge clk);
    tick();
    tick();
    chk(tx_out == 1'b1 && tde == 1'b1, "R2", {tx_out, tde}, 2'b11);

    // R2: second write while full is ignored
    write_byte(8'h3C);
    write_byte(8'hFF);
    chk(tde == 1'b0, "R2", tde, 1'b0);
    recv_check(8'h3C, 1'b0, 1'b0);

    // R7: abort colliding with a tick mid-frame, port set for break
    write_byte(8'h00);
    tick();
    tick();
    tick();
    port_dr  = 1'b0;
    port_ddr = 1'b1;
    tx_en    = 1'b0;
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
    chk(tx_out == 1'b0 && tx_oe == 1'b1 && tde == 1'b1, "R7",
        {tx_out, tx_oe, tde}, 3'b011);
    repeat (3) @(negedge clk);
    chk(tx_out == 1'b0, "R6", tx_out, 1'b0);
    port_dr = 1'b1;
    tx_en = 1'b1;
    @(negedge clk);
    tick();
    chk(tx_out == 1'b1 && tde == 1'b1, "R7", {tx_out, tde}, 2'b11);
    send_check(8'hA5, 1'b0, 1'b0);

    // R8: interlock under synchronous operation, each flag in turn
    sync_mode = 1'b1;
    for (int f = 0; f < 3; f++) begin
      err_overrun = (f == 0);
      err_framing = (f == 1);
      err_parity  = (f == 2);
      write_byte(8'h5A);
      tick();
      tick();
      tick();
      chk(tx_out == 1'b1 && tde == 1'b0, "R8", {tx_out, tde}, 2'b10);
      err_overrun = 1'b0;
      err_framing = 1'b0;
      err_parity  = 1'b0;
      recv_check(8'h5A, 1'b0, 1'b0);
    end

    // R8: flags ignored outside synchronous operation
    sync_mode = 1'b0;
    err_overrun = 1'b1;
    err_framing = 1'b1;
    err_parity = 1'b1;
    send_check(8'h96, 1'b1, 1'b1);
    err_overrun = 1'b0;
    err_framing = 1'b0;
    err_parity = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule